// File: doc/BRIEF.md
# Serial Wiper Code Receiver

This block is the digital control front end of a 256-step programmable resistor divider. A host writes wiper codes over a write-only three-wire serial bus: an active-low select, a serial clock and one data line. The block oversamples all three lines with a fast system clock, collects data bits into a shift register and loads the collected word into the wiper register when the select line is released. The wiper register drives the ladder decoder on the B side. Its bitwise complement, 255 minus the code, drives the A-side decoder.

Frames of any length are accepted. Only the bits received last survive in the shift register. Bits left over from earlier traffic remain in its upper positions when a frame is short. After reset the wiper rests at midscale.

Top module: `wiper_spi_if`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wiper_code` is 0x80, `wiper_comp` is 0x7F and `updated` is 0. After reset the internal shift register holds 0.
- R2: Words are sent most significant bit first. With `cs_n` low, one `sdi` bit is taken on each rising edge of `sclk`. An 8-bit frame with bits b7..b0 loads the code b7..b0.
- R3: `wiper_code` changes only when a frame is committed. It keeps its old value while a frame is in progress, including after all bits of the new frame have been clocked in.
- R4: If more than 8 bits arrive in one frame, the earliest bits are dropped and the last 8 received are committed.
- R5: The shift register is not cleared between frames. A frame of N < 8 bits commits the previous shift contents moved up by N positions, with the N new bits in the low positions. A frame with no clock edges recommits the current shift contents.
- R6: Rising edges of `sclk` while `cs_n` is high do not change the shift register or the wiper register.
- R7: The commit happens on a low-to-high transition of `cs_n`. `wiper_code` takes the new value, and `updated` is high for exactly one cycle, on the 3rd rising edge of `clk` after `cs_n` rises (two synchronizer stages plus the edge detector). At all other times `updated` is 0.
- R8: `wiper_comp` always equals 255 minus `wiper_code`, so code 0x00 gives 0xFF and code 0xFF gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; a rising edge commits the frame |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| wiper_code | output | 8 | Wiper register, drives the B-side decoder |
| wiper_comp | output | 8 | 255 minus the wiper code, drives the A-side decoder |
| updated | output | 1 | One-cycle strobe in the cycle the wiper register loads |

## Verification
The shift register cannot be read out, so an error in it stays hidden until the next rise of `cs_n`. Three cycles after that rise it shows up as a wrong `wiper_code`. Zero-bit and short frames expose the stale upper bits directly, so a shift error in one frame is also visible in the frames that follow. An edge-detection or synchronizer fault appears as a misplaced or doubled `updated` pulse, or as a commit arriving off the expected cycle. The complement output shows its error in the same cycle as any code.

// File: rtl/wiper_spi_if.sv
module wiper_spi_if #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic [W-1:0] wiper_code,
  output logic [W-1:0] wiper_comp,
  output logic         updated
);
  localparam logic [W-1:0] PRESET = W'(1) << (W - 1);

  logic [SYNC_STAGES-1:0] cs_pipe, sclk_pipe, sdi_pipe;
  logic cs_s, sclk_s, sdi_s, cs_q, sclk_q;
  logic [W-1:0] shreg;
  logic shift_en, commit;

  assign cs_s   = cs_pipe[SYNC_STAGES-1];
  assign sclk_s = sclk_pipe[SYNC_STAGES-1];
  assign sdi_s  = sdi_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '0;
      sdi_pipe  <= '0;
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
      sdi_pipe  <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
      cs_q      <= cs_s;
      sclk_q    <= sclk_s;
    end
  end

  assign shift_en = !cs_s && sclk_s && !sclk_q;
  assign commit   = cs_s && !cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      wiper_code <= PRESET;
      updated    <= 1'b0;
    end else begin
      if (shift_en) shreg <= {shreg[W-2:0], sdi_s};
      if (commit) wiper_code <= shreg;
      updated <= commit;
    end
  end

  assign wiper_comp = ~wiper_code;
endmodule

// File: rtl/wiper_spi_if_chk.sv
module wiper_spi_if_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_s,
  input logic         sclk_s,
  input logic         sclk_q,
  input logic [W-1:0] shreg,
  input logic [W-1:0] wiper_code,
  input logic [W-1:0] wiper_comp,
  input logic         updated
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  assert_preset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (wiper_code == MID && !updated));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> (wiper_code == $past(shreg)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_code) |-> updated);

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && sclk_s && !sclk_q) |=> $stable(shreg));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    updated |=> !updated);

  assert_comp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wiper_code} + {1'b0, wiper_comp}) == {1'b0, {W{1'b1}}});
endmodule

bind wiper_spi_if wiper_spi_if_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .sclk_q(sclk_q),
  .shreg(shreg), .wiper_code(wiper_code), .wiper_comp(wiper_comp),
  .updated(updated)
);

// File: tb/sim_wiper_spi_if.sv
module sim_wiper_spi_if;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [7:0] wiper_code, wiper_comp;
  logic updated;
  int checks = 0, fails = 0;
  logic [7:0] m_sh = 8'h00;
  logic [7:0] m_wiper = 8'h80;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wiper_spi_if u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
                   .sdi(sdi), .wiper_code(wiper_code), .wiper_comp(wiper_comp),
                   .updated(updated));

  function automatic logic [7:0] shift_in(logic [7:0] s, logic b);
    return {s[6:0], b};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [31:0] v, int n, string req);
    tick(1);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      tick(HALF);
      sclk = 1'b1;
      m_sh = shift_in(m_sh, v[i]);
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    check({req, "/R3 hold"}, wiper_code, m_wiper);
    check("R7 quiet", {7'd0, updated}, 8'd0);
    cs_n = 1'b1;
    m_wiper = m_sh;
    repeat (2) @(posedge clk);
    #1 check("R7 not early", {7'd0, updated}, 8'd0);
    @(posedge clk);
    #1 check("R7 strobe", {7'd0, updated}, 8'd1);
    check(req, wiper_code, m_wiper);
    check("R8", wiper_comp, 8'd255 - m_wiper);
    @(posedge clk);
    #1 check("R7 single", {7'd0, updated}, 8'd0);
    tick(12);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    check("R1 code", wiper_code, 8'h80);
    check("R1 comp", wiper_comp, 8'h7F);
    check("R1 strobe", {7'd0, updated}, 8'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after", wiper_code, 8'h80);
    tick(4);

    frame(32'h00, 0, "R5 empty after reset");
    frame(32'hA5, 8, "R2");
    frame(32'h00, 8, "R2 zero R8");
    frame(32'hFF, 8, "R2 full R8");
    frame(32'h5A3, 12, "R4");
    frame(32'hBEEF, 16, "R4");
    frame(32'h5, 3, "R5");
    frame(32'h1, 1, "R5");

    for (int k = 0; k < 5; k++) begin
      tick(HALF);
      sdi = 1'($urandom);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    check("R6 wiper", wiper_code, m_wiper);
    frame(32'h0, 0, "R6");

    for (int k = 0; k < 40; k++) begin
      int n;
      n = int'($urandom % 17);
      frame($urandom, n, n > 8 ? "R4 rnd" : (n == 8 ? "R2 rnd" : "R5 rnd"));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule